// File: doc/BRIEF.md
# Monitor Detection Probe Scheduler

This block decides when a short probe pulse is driven onto the blue video line of each output port, so that the termination of an attached display can be sensed. It then turns the sensing result into a filtered monitor-present flag for each port. Probing happens only in automatic switching mode. Two events start a probe. The first is a slow free-running timer, which runs while no port reports an attached state. The second is the trailing edge of the active vertical sync level, so that the probe lands in the back porch rather than in active video.

The sync polarity is not configured. For each edge, the block compares the length of the level run that just ended with the length of the last run of the opposite level. The shorter level is taken as the active sync level. A probe drives all ports at once, for a fixed number of cycles. A one-cycle sample strobe on the last probe cycle captures the per-port comparator result. Each port's flag changes only after two consecutive samples for that port agree. After every probe a guard interval follows, during which further triggers are dropped, and the timer restarts from zero. All durations are parameters counted in clock cycles.

Top module: `mdet_probe_sched`

## Requirements
- R1: While `auto_en_i` is low, no probe starts. If `auto_en_i` drops during a probe, `probe_o` returns to zero on the next cycle and the guard interval follows.
- R2: In automatic mode, with `attached_i` all zero and no sync trigger, successive probes start every PULSE_CYC + GUARD_CYC + TIMER_CYC cycles.
- R3: While any bit of `attached_i` is high, the timer is held at zero and starts no probe.
- R4: With active-high sync (high runs shorter than low runs), a probe starts on the falling edge of `vsync_i`.
- R5: With active-low sync (low runs shorter than high runs), a probe starts on the rising edge of `vsync_i`. An edge that ends a run no shorter than the previous opposite-level run starts nothing.
- R6: A probe holds every bit of `probe_o` high together for exactly PULSE_CYC cycles.
- R7: `strobe_o` is high for exactly one cycle, on the last cycle of a full-length probe.
- R8: Port p's `present_o` bit changes only in the cycle after a strobe, and only when `cmp_i[p]` at that strobe equals `cmp_i[p]` at the previous strobe. It then takes that value. Ports are filtered independently.
- R9: After each probe, triggers are dropped for GUARD_CYC cycles. The timer restarts from zero after any probe, whether the timer or a sync edge started it.
- R10: During and right after reset, `probe_o`, `strobe_o` and `present_o` are all zero.
- R11: `vsync_i` passes through SYNC_STAGES flops. A triggering sync edge raises `probe_o` SYNC_STAGES + 1 cycles after the edge is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_en_i | input | 1 | Automatic switching mode enable |
| vsync_i | input | 1 | Source vertical sync, either polarity, asynchronous |
| attached_i | input | NPORT | Per-port attached-state feedback |
| cmp_i | input | NPORT | Per-port raw termination comparator result |
| probe_o | output | NPORT | Per-port probe pulse enable |
| strobe_o | output | 1 | Comparator sample strobe |
| present_o | output | NPORT | Filtered per-port monitor-present flags |

## Verification
The bound checker enforces these properties on every cycle:
- ports probe together;
- pulse width never exceeds PULSE_CYC, and the strobe sits on its final cycle;
- the minimum low gap before a new probe holds;
- flags move only after a strobe, toward the sampled comparator value;
- no probe appears after a full cycle of manual mode.

Some behaviours only the bench's scenarios can show, through a cycle-by-cycle reference model and targeted checks:
- the timer period;
- the hold while a port is attached;
- polarity inference for both sync polarities, with its latency;
- the two-sample agreement per port;
- the timer restart after a sync-initiated probe.

// File: rtl/mdet_pkg.sv
`timescale 1ns/1ps
package mdet_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PULSE = 2'd1,
    SEQ_GUARD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mdet_vsync_trig.sv
`timescale 1ns/1ps
module mdet_vsync_trig #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RUN_W       = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  output logic trig_o
);
  localparam logic [RUN_W-1:0] RunMax = '1;
  localparam logic [RUN_W-1:0] RunOne = RUN_W'(1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_q;
  logic                   lvl_s;
  logic                   edge_s;
  logic [RUN_W-1:0]       run_q;
  logic [RUN_W-1:0]       hi_len_q;
  logic [RUN_W-1:0]       lo_len_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= vsync_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign lvl_s  = sync_q[SYNC_STAGES-1];
  assign edge_s = lvl_s ^ lvl_q;

  // trailing edge of the shorter (active) level
  assign trig_o = edge_s && (lvl_q ? (run_q < lo_len_q) : (run_q < hi_len_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q    <= 1'b0;
      run_q    <= '0;
      hi_len_q <= '0;
      lo_len_q <= '0;
    end else begin
      lvl_q <= lvl_s;
      if (edge_s) begin
        run_q <= RunOne;
        if (lvl_q) hi_len_q <= run_q;
        else       lo_len_q <= run_q;
      end else if (run_q != RunMax) begin
        run_q <= run_q + RunOne;
      end
    end
  end
endmodule

// File: rtl/mdet_seq.sv
`timescale 1ns/1ps
module mdet_seq
  import mdet_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 250,
  parameter int unsigned GUARD_CYC = 250,
  parameter int unsigned TIMER_CYC = 16_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_en_i,
  input  logic quiet_i,
  input  logic sync_trig_i,
  output logic busy_o,
  output logic strobe_o
);
  localparam int unsigned CntMax = (PULSE_CYC > GUARD_CYC) ? PULSE_CYC : GUARD_CYC;
  localparam int unsigned CntW   = $clog2(CntMax + 1);
  localparam int unsigned TmrW   = $clog2(TIMER_CYC + 1);
  localparam logic [CntW-1:0] PulseLast = CntW'(PULSE_CYC - 1);
  localparam logic [CntW-1:0] GuardLast = CntW'(GUARD_CYC - 1);
  localparam logic [CntW-1:0] CntOne    = CntW'(1);
  localparam logic [TmrW-1:0] TmrLast   = TmrW'(TIMER_CYC - 1);
  localparam logic [TmrW-1:0] TmrOne    = TmrW'(1);

  seq_state_e      st_q, st_d;
  logic [CntW-1:0] cnt_q, cnt_d;
  logic [TmrW-1:0] tmr_q, tmr_d;
  logic            fire;

  assign fire = auto_en_i && (sync_trig_i || (quiet_i && (tmr_q == TmrLast)));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    tmr_d = '0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (fire) begin
          st_d  = SEQ_PULSE;
          cnt_d = '0;
        end else if (auto_en_i && quiet_i) begin
          tmr_d = tmr_q + TmrOne;
        end
      end
      SEQ_PULSE: begin
        if (!auto_en_i || (cnt_q == PulseLast)) begin
          st_d  = SEQ_GUARD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CntOne;
        end
      end
      SEQ_GUARD: begin
        if (cnt_q == GuardLast) begin
          st_d  = SEQ_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CntOne;
        end
      end
      default: begin
        st_d  = SEQ_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tmr_q <= tmr_d;
    end
  end

  assign busy_o   = (st_q == SEQ_PULSE);
  assign strobe_o = busy_o && (cnt_q == PulseLast);
endmodule

// File: rtl/mdet_flag.sv
`timescale 1ns/1ps
module mdet_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic cmp_i,
  output logic present_o
);
  logic last_q;
  logic present_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q    <= 1'b0;
      present_q <= 1'b0;
    end else if (strobe_i) begin
      last_q <= cmp_i;
      if (cmp_i == last_q) present_q <= cmp_i;
    end
  end

  assign present_o = present_q;
endmodule

// File: rtl/mdet_probe_sched.sv
`timescale 1ns/1ps
module mdet_probe_sched
  import mdet_pkg::*;
#(
  parameter int unsigned NPORT       = 2,
  parameter int unsigned PULSE_CYC   = 250,
  parameter int unsigned GUARD_CYC   = 250,
  parameter int unsigned TIMER_CYC   = 16_000_000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RUN_W       = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_en_i,
  input  logic             vsync_i,
  input  logic [NPORT-1:0] attached_i,
  input  logic [NPORT-1:0] cmp_i,
  output logic [NPORT-1:0] probe_o,
  output logic             strobe_o,
  output logic [NPORT-1:0] present_o
);
  logic sync_trig;
  logic busy;
  logic quiet;

  assign quiet = ~|attached_i;

  mdet_vsync_trig #(
    .SYNC_STAGES(SYNC_STAGES),
    .RUN_W      (RUN_W)
  ) u_vtrig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vsync_i(vsync_i),
    .trig_o (sync_trig)
  );

  mdet_seq #(
    .PULSE_CYC(PULSE_CYC),
    .GUARD_CYC(GUARD_CYC),
    .TIMER_CYC(TIMER_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .auto_en_i  (auto_en_i),
    .quiet_i    (quiet),
    .sync_trig_i(sync_trig),
    .busy_o     (busy),
    .strobe_o   (strobe_o)
  );

  assign probe_o = {NPORT{busy}};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mdet_flag u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe_o),
      .cmp_i    (cmp_i[p]),
      .present_o(present_o[p])
    );
  end
endmodule

// File: rtl/mdet_probe_sched_chk.sv
`timescale 1ns/1ps
module mdet_probe_sched_chk #(
  parameter int unsigned NPORT     = 2,
  parameter int unsigned PULSE_CYC = 250,
  parameter int unsigned GUARD_CYC = 250
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             auto_en_i,
  input logic [NPORT-1:0] cmp_i,
  input logic [NPORT-1:0] probe_o,
  input logic             strobe_o,
  input logic [NPORT-1:0] present_o
);
  localparam int unsigned CW = 32;
  localparam logic [CW-1:0] PulseLim = CW'(PULSE_CYC);
  localparam logic [CW-1:0] PulseLst = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] GuardLim = CW'(GUARD_CYC);

  logic [CW-1:0] hi_run;
  logic [CW-1:0] lo_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= '0;
      lo_run <= GuardLim;
    end else begin
      hi_run <= probe_o[0] ? hi_run + 1 : '0;
      if (probe_o[0])          lo_run <= '0;
      else if (lo_run < GuardLim) lo_run <= lo_run + 1;
    end
  end

  a_r1_manual_no_probe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_en_i && !$past(auto_en_i)) |-> (probe_o == '0));

  a_r6_ports_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_o == '0) || (probe_o == '1));

  a_r6_width_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_o[0] |-> (hi_run < PulseLim));

  a_r7_strobe_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (probe_o[0] && (hi_run == PulseLst)));

  a_r7_probe_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> (probe_o == '0));

  a_r8_flag_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_o != $past(present_o)) |-> $past(strobe_o));

  a_r8_flag_follows_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (present_o != $past(present_o)) |->
      (((present_o ^ $past(present_o)) & (present_o ^ $past(cmp_i))) == '0));

  a_r9_guard_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(probe_o[0]) |-> (lo_run >= GuardLim));
endmodule

bind mdet_probe_sched mdet_probe_sched_chk #(
  .NPORT    (NPORT),
  .PULSE_CYC(PULSE_CYC),
  .GUARD_CYC(GUARD_CYC)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .auto_en_i(auto_en_i),
  .cmp_i    (cmp_i),
  .probe_o  (probe_o),
  .strobe_o (strobe_o),
  .present_o(present_o)
);

// File: tb/sim_mdet_probe_sched.sv
`timescale 1ns/1ps
module sim_mdet_probe_sched;
  localparam int NP = 2;
  localparam int P  = 4;
  localparam int G  = 6;
  localparam int T  = 50;
  localparam int S  = 2;
  localparam int RW = 12;
  localparam int RUNMAX = (1 << RW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_en = 1'b0;
  logic vs = 1'b0;
  logic [NP-1:0] att = '0;
  logic [NP-1:0] cmp = '0;
  logic [NP-1:0] probe;
  logic strobe;
  logic [NP-1:0] pres;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mdet_probe_sched #(
    .NPORT(NP), .PULSE_CYC(P), .GUARD_CYC(G), .TIMER_CYC(T),
    .SYNC_STAGES(S), .RUN_W(RW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .auto_en_i(auto_en), .vsync_i(vs),
    .attached_i(att), .cmp_i(cmp), .probe_o(probe), .strobe_o(strobe),
    .present_o(pres)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int cyc = 0;
  bit m_sync[$];
  bit m_lvl;
  int m_run, m_hi, m_lo;
  int m_phase, m_cnt, m_tmr; // phase: 0 idle, 1 probing, 2 guard
  bit m_last[NP];
  bit m_pres[NP];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = {};
      for (int i = 0; i < S; i++) m_sync.push_back(1'b0);
      m_lvl = 0; m_run = 0; m_hi = 0; m_lo = 0;
      m_phase = 0; m_cnt = 0; m_tmr = 0;
      for (int p = 0; p < NP; p++) begin m_last[p] = 0; m_pres[p] = 0; end
    end else begin
      bit cur, edg, trg, fire, stb;
      cyc++;
      cur  = m_sync[S-1];
      edg  = (cur != m_lvl);
      trg  = edg && (m_lvl ? (m_run < m_lo) : (m_run < m_hi));
      fire = auto_en && (trg || (att == 0 && m_tmr == T - 1));
      stb  = (m_phase == 1) && (m_cnt == P - 1);
      if (stb)
        for (int p = 0; p < NP; p++) begin
          if (cmp[p] == m_last[p]) m_pres[p] = cmp[p];
          m_last[p] = cmp[p];
        end
      case (m_phase)
        0: begin
          if (fire) begin m_phase = 1; m_cnt = 0; m_tmr = 0; end
          else if (auto_en && att == 0) m_tmr++;
          else m_tmr = 0;
        end
        1: begin
          m_tmr = 0;
          if (!auto_en || m_cnt == P - 1) begin m_phase = 2; m_cnt = 0; end
          else m_cnt++;
        end
        default: begin
          m_tmr = 0;
          if (m_cnt == G - 1) begin m_phase = 0; m_cnt = 0; end
          else m_cnt++;
        end
      endcase
      if (edg) begin
        if (m_lvl) m_hi = m_run; else m_lo = m_run;
        m_run = 1;
      end else if (m_run < RUNMAX) m_run++;
      m_lvl = cur;
      void'(m_sync.pop_back());
      m_sync.push_front(vs);
    end
  end

  // ---------------- compare and monitor ----------------
  bit prev_p = 0;
  int rises = 0, t_rise = 0, t_rise_prev = 0, t_fall = -1000, min_gap = 1000;

  always @(negedge clk) begin
    if (rst_n) begin
      int ep, ex;
      ep = (m_phase == 1) ? 3 : 0;
      check(probe == NP'(ep), "R6 probe", int'(probe), ep);
      check(strobe == ((m_phase == 1) && (m_cnt == P - 1)), "R7 strobe",
            int'(strobe), int'((m_phase == 1) && (m_cnt == P - 1)));
      ex = {30'd0, m_pres[1], m_pres[0]};
      check(pres == NP'(ex), "R8 present", int'(pres), ex);
      if (probe[0] && !prev_p) begin
        rises++;
        t_rise_prev = t_rise;
        t_rise = cyc;
        if (cyc - t_fall < min_gap) min_gap = cyc - t_fall;
      end
      if (!probe[0] && prev_p) t_fall = cyc;
      prev_p = probe[0];
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_strobe();
    while (!strobe) tick();
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected 0 (run did not complete)", cyc);
    finish_run();
  end

  initial begin
    int r0;
    tick(3);
    // R10 reset state
    check(probe == 0 && strobe == 0 && pres == 0, "R10 in reset", int'(probe), 0);
    rst_n = 1'b1;
    tick();
    check(probe == 0 && strobe == 0 && pres == 0, "R10 after reset", int'(pres), 0);

    // R1 manual mode: vsync toggling, nothing attached, no probes
    r0 = rises;
    repeat (10) begin vs = 1; tick(10); vs = 0; tick(10); end
    tick(50);
    check(rises == r0, "R1 manual no probe", rises - r0, 0);

    // R2 timer probes and R8 two-sample filter per port
    cmp = 2'b01; auto_en = 1;
    wait_strobe();
    check(pres == 2'b00, "R8 single sample holds", int'(pres), 0);
    wait_strobe();
    check(pres == 2'b01, "R8 two agreeing samples", int'(pres), 1);
    check(t_rise - t_rise_prev == P + G + T, "R2 timer period", t_rise - t_rise_prev, P + G + T);
    cmp = 2'b10;
    wait_strobe();
    check(pres == 2'b01, "R8 disagreement holds", int'(pres), 1);
    wait_strobe();
    check(pres == 2'b10, "R8 ports independent", int'(pres), 2);

    // R3 attached port holds the timer
    att = 2'b01;
    tick(20);
    r0 = rises;
    tick(300);
    check(rises == r0, "R3 no timer probe while attached", rises - r0, 0);

    // R4 active-high sync, R11 latency
    repeat (6) begin
      vs = 1; tick(5);
      vs = 0; tick(2);
      check(probe == 0, "R11 not before latency", int'(probe), 0);
      tick();
      check(probe == 2'b11, "R4 probe after falling edge", int'(probe), 3);
      tick(32);
    end

    // R5 active-low sync
    vs = 1; tick(60);
    repeat (6) begin
      vs = 0; tick(5);
      vs = 1; tick(2);
      check(probe == 0, "R11 not before latency", int'(probe), 0);
      tick();
      check(probe == 2'b11, "R5 probe after rising edge", int'(probe), 3);
      tick(32);
    end

    // R9 guard: sync edges closer than probe plus guard
    min_gap = 1000;
    r0 = rises;
    repeat (10) begin vs = 0; tick(2); vs = 1; tick(6); end
    tick(20);
    check(rises > r0 + 2, "R9 some sync probes issued", rises - r0, 3);
    check(min_gap >= G + 1, "R9 guard gap", min_gap, G + 1);

    // R9 timer restart after a sync-initiated probe
    att = 2'b00;
    r0 = rises;
    while (rises == r0) tick();
    tick(20);
    vs = 0; tick(3); vs = 1;
    while (rises < r0 + 2) tick();
    check(t_rise - t_rise_prev < P + G + T, "R9 sync probe before timer", t_rise - t_rise_prev, P + G + T - 1);
    while (rises < r0 + 3) tick();
    check(t_rise - t_rise_prev == P + G + T, "R9 timer restarted", t_rise - t_rise_prev, P + G + T);

    // R1 abort on leaving auto mode
    while (!probe[0]) tick();
    tick();
    auto_en = 0;
    tick();
    check(probe == 0, "R1 abort ends probe", int'(probe), 0);
    r0 = rises;
    tick(150);
    check(rises == r0, "R1 no probe after abort", rises - r0, 0);

    finish_run();
  end
endmodule